// File: doc/BRIEF.md
# Watchdog and Failsafe Output Controller

This block supervises a watchdog for a switch array of four high-side and eight low-side output channels, and it decides what each channel may do. The system side services the watchdog by changing the level of a kick line or by changing the watchdog bit carried by each received serial (SPI) word. If the watchdog is not serviced in time, the block locks into a failsafe state. In that state two fixed high-side channels are forced on and every other channel is forced off.

The wake line and the active-low run line, both synchronized, select the operating state: sleep, hold, default or normal. In default mode the channels follow the direct input pins. In normal mode they follow commands decoded from SPI. A strap input turns off the watchdog and the failsafe state entirely. The timeout is a base count of prescaled ticks, and a 2-bit divider can shorten it by a shift of 0 to 3.

Top module: `wdfs_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (sleep) and every high-side and low-side output is off.
- R2: A rising edge on either the wake line or the run line arms the watchdog and starts a fresh timeout, when the strap is high.
- R3: While armed, any change of the synchronized kick-line level reloads the timeout. So does an SPI word whose watchdog bit differs from the bit in the previous SPI word. An SPI word that repeats the previous bit does not reload.
- R4: After a reload, failsafe (mode_o = 4) shows exactly PRESCALE * max(1, WD_LOAD >> wd_div) clock edges later if no further reload occurs. The divider value is taken at the reload.
- R5: In failsafe, hs_out equals FS_HS_MASK (channels 0 and 2 on, i.e. 4'b0101), and ls_out is all zero, whatever the direct pins and the SPI commands are.
- R6: Failsafe is left only when the wake line and the run line are both low. While either line is high, failsafe holds. This covers a wake-armed watchdog, where the run line going low is not enough, and a run-armed watchdog with wake low, where the run line going low alone clears it.
- R7: With the strap low, the watchdog never expires and failsafe is never entered.
- R8: mode_o encodes 0 = sleep (both lines low) and 1 = hold (wake high, run line low, no failsafe). In both modes all outputs are off.
- R9: With the run line high and no SPI word received since it rose, mode_o is 2 (default). Each hs_out bit follows its hs_direct pin, and every ls_out bit follows ls_direct.
- R10: After an SPI word is received while the run line is high, mode_o is 3 (normal), hs_out equals hs_cmd and ls_out equals ls_cmd. Taking the run line low and high again returns the block to default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_line | input | 1 | Wake line, asynchronous |
| run_line_n | input | 1 | Active-low run/reset line, asynchronous (high = running) |
| kick_line | input | 1 | Watchdog kick line, asynchronous |
| guard_strap | input | 1 | Strap: 1 enables watchdog and failsafe, 0 disables them |
| spi_stb | input | 1 | One-cycle strobe per received SPI word |
| spi_wd_bit | input | 1 | Watchdog bit of the SPI word, valid with spi_stb |
| wd_div | input | 2 | Timeout shift, 0 to 3 |
| hs_direct | input | NHS | Direct high-side control pins |
| ls_direct | input | 1 | Shared direct low-side control pin |
| hs_cmd | input | NHS | High-side commands from SPI |
| ls_cmd | input | NLS | Low-side commands from SPI |
| hs_out | output | NHS | High-side channel enables |
| ls_out | output | NLS | Low-side channel enables |
| mode_o | output | 3 | Operating mode code |

## Verification
The bench sweeps all four divider settings and measures the exact cycle at which failsafe appears. A design with an off-by-one tick, or one that applies the shift late, shows up in that count. Repeated-bit SPI words are sent after a run of kick toggles: a design that reloads on every strobe, and not on a change of the bit, would never reach failsafe there. Both exit paths are driven. With a wake-armed failsafe, dropping only the run line must leave the block locked; a design that checked the run line alone would release it there. Exhaustive sweeps of the direct pins and commands in default, normal and failsafe mode catch any leak of a command through the forced pattern.

// File: rtl/wdfs_pkg.sv
package wdfs_pkg;

  localparam int WD_CNT_W = 16;

  typedef enum logic [2:0] {
    MODE_SLEEP    = 3'd0,
    MODE_HOLD     = 3'd1,
    MODE_DEFAULT  = 3'd2,
    MODE_NORMAL   = 3'd3,
    MODE_FAILSAFE = 3'd4
  } wdfs_mode_e;

  // Reload value: base count shifted by the divider, never below one tick.
  function automatic logic [WD_CNT_W-1:0] wd_reload(input logic [WD_CNT_W-1:0] base,
                                                    input logic [1:0] sh);
    logic [WD_CNT_W-1:0] v;
    v = base >> sh;
    if (v == '0) v = {{(WD_CNT_W-1){1'b0}}, 1'b1};
    return v;
  endfunction

endpackage

// File: rtl/wdfs_sync.sv
module wdfs_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= d_async[g];
        stab_q <= meta_q;
      end
    end
    assign q_sync[g] = stab_q;
  end
endmodule

// File: rtl/wdfs_timer.sv
module wdfs_timer
  import wdfs_pkg::*;
#(
  parameter int                  PRESCALE = 64,
  parameter logic [WD_CNT_W-1:0] WD_LOAD  = 16'd1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reload,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       expire,
  output logic       tick
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]    pre_q;
  logic [WD_CNT_W-1:0] cnt_q;

  assign tick   = run && (pre_q == PRE_LAST);
  assign expire = tick && !reload && (cnt_q == {{(WD_CNT_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (reload) begin
      pre_q <= '0;
      cnt_q <= wd_reload(WD_LOAD, div_sel);
    end else if (run) begin
      if (tick) begin
        pre_q <= '0;
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdfs_supervisor.sv
module wdfs_supervisor
  import wdfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_s,
  input  logic       run_s,
  input  logic       kick_s,
  input  logic       strap_s,
  input  logic       spi_stb,
  input  logic       spi_wd_bit,
  input  logic       expire,
  output logic       reload,
  output logic       run,
  output logic       both_low,
  output logic       fs_q,
  output wdfs_mode_e mode
);
  logic wake_d, run_d, kick_d, spi_last_q;
  logic armed_q, spi_seen_q;
  logic arm_evt, kick_tgl, spi_tgl;

  assign both_low = !wake_s && !run_s;
  assign arm_evt  = strap_s && ((wake_s && !wake_d) || (run_s && !run_d));
  assign kick_tgl = kick_s ^ kick_d;
  assign spi_tgl  = spi_stb && (spi_wd_bit ^ spi_last_q);
  assign reload   = arm_evt || (armed_q && (kick_tgl || spi_tgl));
  assign run      = armed_q && strap_s && !fs_q && !both_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_d     <= 1'b0;
      run_d      <= 1'b0;
      kick_d     <= 1'b0;
      spi_last_q <= 1'b0;
    end else begin
      wake_d <= wake_s;
      run_d  <= run_s;
      kick_d <= kick_s;
      if (spi_stb) spi_last_q <= spi_wd_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      fs_q    <= 1'b0;
    end else if (!strap_s || both_low) begin
      armed_q <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      if (arm_evt) armed_q <= 1'b1;
      if (expire)  fs_q    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spi_seen_q <= 1'b0;
    else if (!run_s)  spi_seen_q <= 1'b0;
    else if (spi_stb) spi_seen_q <= 1'b1;
  end

  always_comb begin
    if (fs_q)            mode = MODE_FAILSAFE;
    else if (!run_s)     mode = wake_s ? MODE_HOLD : MODE_SLEEP;
    else if (spi_seen_q) mode = MODE_NORMAL;
    else                 mode = MODE_DEFAULT;
  end
endmodule

// File: rtl/wdfs_outgate.sv
module wdfs_outgate
  import wdfs_pkg::*;
#(
  parameter int             NHS        = 4,
  parameter int             NLS        = 8,
  parameter logic [NHS-1:0] FS_HS_MASK = 4'b0101
) (
  input  wdfs_mode_e     mode,
  input  logic [NHS-1:0] hs_direct,
  input  logic           ls_direct,
  input  logic [NHS-1:0] hs_cmd,
  input  logic [NLS-1:0] ls_cmd,
  output logic [NHS-1:0] hs_out,
  output logic [NLS-1:0] ls_out
);
  logic is_fs, is_def, is_norm;
  assign is_fs   = (mode == MODE_FAILSAFE);
  assign is_def  = (mode == MODE_DEFAULT);
  assign is_norm = (mode == MODE_NORMAL);

  for (genvar h = 0; h < NHS; h++) begin : g_hs
    assign hs_out[h] = is_fs   ? FS_HS_MASK[h] :
                       is_def  ? hs_direct[h]  :
                       is_norm ? hs_cmd[h]     : 1'b0;
  end

  for (genvar l = 0; l < NLS; l++) begin : g_ls
    assign ls_out[l] = is_def  ? ls_direct :
                       is_norm ? ls_cmd[l] : 1'b0;
  end
endmodule

// File: rtl/wdfs_ctrl.sv
module wdfs_ctrl
  import wdfs_pkg::*;
#(
  parameter int                  NHS        = 4,
  parameter int                  NLS        = 8,
  parameter logic [NHS-1:0]      FS_HS_MASK = 4'b0101,
  parameter int                  PRESCALE   = 64,
  parameter logic [WD_CNT_W-1:0] WD_LOAD    = 16'd1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wake_line,
  input  logic           run_line_n,
  input  logic           kick_line,
  input  logic           guard_strap,
  input  logic           spi_stb,
  input  logic           spi_wd_bit,
  input  logic [1:0]     wd_div,
  input  logic [NHS-1:0] hs_direct,
  input  logic           ls_direct,
  input  logic [NHS-1:0] hs_cmd,
  input  logic [NLS-1:0] ls_cmd,
  output logic [NHS-1:0] hs_out,
  output logic [NLS-1:0] ls_out,
  output logic [2:0]     mode_o
);
  logic [3:0] pins_s;
  logic       wake_s, run_s, kick_s, strap_s;
  logic       reload, run, both_low, fs_q, expire, tick;
  wdfs_mode_e mode;

  wdfs_sync #(.W(4), .RST_VAL(4'b1000)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({guard_strap, kick_line, run_line_n, wake_line}),
    .q_sync  (pins_s)
  );
  assign {strap_s, kick_s, run_s, wake_s} = pins_s;

  wdfs_supervisor u_sup (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_s     (wake_s),
    .run_s      (run_s),
    .kick_s     (kick_s),
    .strap_s    (strap_s),
    .spi_stb    (spi_stb),
    .spi_wd_bit (spi_wd_bit),
    .expire     (expire),
    .reload     (reload),
    .run        (run),
    .both_low   (both_low),
    .fs_q       (fs_q),
    .mode       (mode)
  );

  wdfs_timer #(.PRESCALE(PRESCALE), .WD_LOAD(WD_LOAD)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (reload),
    .run     (run),
    .div_sel (wd_div),
    .expire  (expire),
    .tick    (tick)
  );

  wdfs_outgate #(.NHS(NHS), .NLS(NLS), .FS_HS_MASK(FS_HS_MASK)) u_out (
    .mode      (mode),
    .hs_direct (hs_direct),
    .ls_direct (ls_direct),
    .hs_cmd    (hs_cmd),
    .ls_cmd    (ls_cmd),
    .hs_out    (hs_out),
    .ls_out    (ls_out)
  );

  assign mode_o = mode;
endmodule

// File: rtl/wdfs_checker.sv
module wdfs_checker
  import wdfs_pkg::*;
#(
  parameter int             NHS        = 4,
  parameter int             NLS        = 8,
  parameter logic [NHS-1:0] FS_HS_MASK = 4'b0101
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     mode_o,
  input logic [NHS-1:0] hs_out,
  input logic [NLS-1:0] ls_out,
  input logic [NHS-1:0] hs_direct,
  input logic           ls_direct,
  input logic           strap_s,
  input logic           fs_q,
  input logic           both_low,
  input logic           expire,
  input logic           tick
);
  AST_FS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_FAILSAFE) |-> (hs_out == FS_HS_MASK && ls_out == '0)); // R5
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_SLEEP || mode_o == MODE_HOLD) |-> (hs_out == '0 && ls_out == '0)); // R8
  AST_DEFAULT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_DEFAULT) |-> (hs_out == hs_direct && ls_out == {NLS{ls_direct}})); // R9
  AST_STRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_s |=> !fs_q); // R7
  AST_FS_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && strap_s && !both_low) |=> fs_q); // R6
  AST_FS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && both_low) |=> !fs_q); // R6
  AST_EXPIRE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> fs_q); // R4
  AST_FS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_q) |-> $past(expire)); // R4
  AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick); // R4
endmodule

bind wdfs_ctrl wdfs_checker #(.NHS(NHS), .NLS(NLS), .FS_HS_MASK(FS_HS_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_o    (mode_o),
  .hs_out    (hs_out),
  .ls_out    (ls_out),
  .hs_direct (hs_direct),
  .ls_direct (ls_direct),
  .strap_s   (strap_s),
  .fs_q      (fs_q),
  .both_low  (both_low),
  .expire    (expire),
  .tick      (tick)
);

// File: tb/wdfs_ctrl_bench.sv
`timescale 1ns/1ps
module wdfs_ctrl_bench;
  localparam int P    = 2;
  localparam int LOAD = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wake_line = 0, run_line_n = 0, kick_line = 0, guard_strap = 1;
  logic       spi_stb = 0, spi_wd_bit = 0;
  logic [1:0] wd_div = 0;
  logic [3:0] hs_direct = 0, hs_cmd = 0;
  logic       ls_direct = 0;
  logic [7:0] ls_cmd = 0;
  logic [3:0] hs_out;
  logic [7:0] ls_out;
  logic [2:0] mode_o;

  int errors = 0, checks = 0;
  logic sb = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wdfs_ctrl #(.PRESCALE(P), .WD_LOAD(16'(LOAD))) u_wdfs_ctrl (
    .clk(clk), .rst_n(rst_n), .wake_line(wake_line), .run_line_n(run_line_n),
    .kick_line(kick_line), .guard_strap(guard_strap), .spi_stb(spi_stb),
    .spi_wd_bit(spi_wd_bit), .wd_div(wd_div), .hs_direct(hs_direct),
    .ls_direct(ls_direct), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
    .hs_out(hs_out), .ls_out(ls_out), .mode_o(mode_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic spi_send(input logic b);
    @(negedge clk);
    spi_stb = 1; spi_wd_bit = b;
    @(posedge clk);
    #1 spi_stb = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (mode_o == 3'd4) break;
    end
  endtask

  function automatic int expect_cycles(input int d);
    int v = LOAD / (1 << d);
    if (v < 1) v = 1;
    return P * v;
  endfunction

  initial begin
    #750000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    step(3); rst_n = 1; step(1);
    // R1 reset state
    chk("R1 mode", mode_o, 0); chk("R1 hs", hs_out, 0); chk("R1 ls", ls_out, 0);

    // R8 hold: wake high, run line low
    hs_direct = 4'hF; ls_direct = 1; wake_line = 1; step(4);
    chk("R8 hold mode", mode_o, 1); chk("R8 hold hs", hs_out, 0); chk("R8 hold ls", ls_out, 0);
    // R2 wake rise armed watchdog -> failsafe
    step(30);
    chk("R2 wake arm expiry", mode_o, 4);
    chk("R5 hs", hs_out, 5); chk("R5 ls", ls_out, 0);
    step(10); chk("R6 wake high holds", mode_o, 4);
    wake_line = 0; step(4); chk("R6 both low exit", mode_o, 0);

    // R7 strap off, R9 default sweep
    guard_strap = 0; step(4); run_line_n = 1; step(4);
    chk("R9 default mode", mode_o, 2);
    for (int k = 0; k < 32; k++) begin
      hs_direct = k[3:0]; ls_direct = k[4]; #0.2;
      chk("R9 hs follow", hs_out, k[3:0]);
      chk("R9 ls follow", ls_out, k[4] ? 8'hFF : 8'h00);
    end
    step(100); chk("R7 strap no failsafe", mode_o, 2);

    // R10 normal mode
    spi_send(0); step(1); chk("R10 normal mode", mode_o, 3);
    for (int i = 0; i < 16; i++) begin
      hs_cmd = i[3:0]; ls_cmd = 8'(i * 17) ^ 8'h5A; hs_direct = ~i[3:0]; #0.2;
      chk("R10 hs cmd", hs_out, i[3:0]);
      chk("R10 ls cmd", ls_out, 8'(i * 17) ^ 8'h5A);
    end
    run_line_n = 0; step(4); chk("R8 sleep", mode_o, 0);
    run_line_n = 1; step(4); chk("R10 back to default", mode_o, 2);
    run_line_n = 0; step(4);

    // R4 timing sweep, R6 run-only exit
    guard_strap = 1; step(4);
    for (int d = 0; d < 4; d++) begin
      wd_div = 0; run_line_n = 1; step(6);
      wd_div = 2'(d); sb = ~sb; spi_send(sb);
      measure(n);
      chk($sformatf("R4 div=%0d cycles", d), n, expect_cycles(d));
      chk("R5 hs in failsafe", hs_out, 5);
      run_line_n = 0; step(4); chk("R6 run-only exit", mode_o, 0);
    end

    // R3 service by kick toggles, not by repeated SPI bit
    wd_div = 0; run_line_n = 1; step(6);
    for (int i = 0; i < 6; i++) begin kick_line = ~kick_line; step(16); end
    chk("R3 kick keeps alive", mode_o, 2);
    for (int j = 0; j < 3; j++) begin spi_send(sb); step(7); end
    chk("R3 repeated bit no reload", mode_o, 4);
    run_line_n = 0; step(4);
    run_line_n = 1; step(6);
    for (int i = 0; i < 6; i++) begin sb = ~sb; spi_send(sb); step(15); end
    chk("R3 spi toggles keep alive", mode_o, 3);
    run_line_n = 0; step(4);

    // R6 wake-armed failsafe, R5 forced pattern sweep
    wake_line = 1; run_line_n = 1; step(40);
    chk("R2 run/wake armed expiry", mode_o, 4);
    for (int k = 0; k < 16; k++) begin
      hs_direct = k[3:0]; ls_direct = k[0]; hs_cmd = ~k[3:0]; ls_cmd = 8'hFF; #0.2;
      chk("R5 hs forced", hs_out, 5); chk("R5 ls forced", ls_out, 0);
    end
    run_line_n = 0; step(6); chk("R6 run low alone holds", mode_o, 4);
    wake_line = 0; step(4); chk("R6 both low exit", mode_o, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule